// File: doc/BRIEF.md
# Serial Digital Audio Frame Transmitter

This block turns a stream of left/right audio sample pairs into a consumer-format serial digital audio line. Each stereo frame has two subframes of 32 time slots. Slots 0 to 3 hold a synchronisation preamble. Slots 4 to 27 hold the audio word, sent LSB first. The next four slots hold the validity, user, channel-status and parity bits. The line is biphase-mark coded, so every slot is two line cells.

A one-cycle strobe, `cell_en`, advances the line by one cell. It runs at 128 times the sample rate. Sample pairs arrive over a valid/ready handshake, already placed so that the most significant audio bit is at bit 27 of each input word. One pair is taken at the start of every frame.

Software programs the block through a write-only register port:
- a control word: enable, the output-side and input-side reset releases, mute (sent as the validity flag) and mono;
- two independent 192-bit channel-status blocks, one for each subframe, each loaded as six 32-bit words.

The recommended start-up order is: release the output side, then release the input side, then set enable. Clearing enable silences the line at once.

Top module: `spdif_tx`

## Requirements
- R1: Framing and timing.
  - The line changes only on the clock after a cycle with `cell_en` high.
  - A frame is 128 cells: subframe 1 (cells 0 to 63), then subframe 2 (cells 64 to 127).
  - Each subframe has 32 slots of two cells each.
- R2: Biphase-mark coding in slots 4 to 31.
  - The line toggles on the first cell of every slot.
  - The line toggles again on the second cell only when the slot bit is 1.
- R3: Preambles in slots 0 to 3.
  - Patterns, cell by cell, when the line was low before the subframe:
    - start of a 192-frame block: 11101000
    - other subframe 1: 11100010
    - subframe 2: 11100100
  - Each pattern is inverted when the line was high before the subframe.
  - The block-start pattern is used on subframe 1 of frame 0, where the frame counter runs 0 to 191 and then wraps.
- R4: Audio slots.
  - Slots 4 to 27 carry bits 4 to 27 of the input word, one bit per slot, lowest first.
  - Input bits 3:0 and 31:28 have no effect on the line.
  - In stereo, subframe 1 carries the left word and subframe 2 the right word.
  - In mono (control bit 4 set), both subframes carry the left word.
- R5: Slot 28 (validity) equals the mute control bit (control bit 3). Slot 29 (user) is always 0.
- R6: Channel-status slot and blocks.
  - Slot 30 carries bit f of block A in subframe 1 and bit f of block B in subframe 2, where f is the frame counter.
  - Block A is written at addresses 1 to 6, block B at addresses 7 to 12.
  - Word w of a block holds block bits 32w to 32w+31, with the lowest bit in the word's LSB.
- R7: Slot 31 is the even-parity bit, so slots 4 to 31 together hold an even number of ones.
- R8: Control word at address 0.
  - Bit 0 is enable, bit 1 is the output-side release and bit 2 is the input-side release.
  - Frames are sent only while all three bits are set.
  - Otherwise the line is driven 0 from the next clock on, and the counters restart, so the next start begins with frame 0 and the block-start preamble.
- R9: Sample handshake.
  - A pair is accepted in a cycle with `smp_valid` and `smp_ready` both high.
  - `smp_ready` is high only while the input-side release is set and the one-pair holding register is empty.
  - The held pair is moved into the frame on cell 0 of each frame. If no pair is held, zeros are sent.
  - Clearing the input-side release discards the held pair.
- R10: After reset the line is 0, `smp_ready` is 0 and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_en | input | 1 | Strobe, one line cell per pulse (128 × sample rate) |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register can take a pair |
| smp_left | input | 32 | Left word, audio MSB at bit 27 |
| smp_right | input | 32 | Right word, audio MSB at bit 27 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| spdif_out | output | 1 | Biphase-mark coded serial line |

## Verification
The assertions assume the following:
- `cell_en` is a single-cycle strobe.
- The control word does not drop and restore the transmit condition inside a subframe without the counters restarting. The parity-level check compares the line at each subframe boundary with the level captured at the previous boundary, which relies on this.

The stimulus keeps within these limits:
- It changes mute and mono only at frame boundaries.
- It stops transmission only by clearing control bits, which restarts the counters.
- It cuts the sample feed only between cells, so each frame's sample pair can be predicted from the count of accepted pairs.

// File: rtl/spdif_tx_pkg.sv
// Shared types for the serial audio transmitter.
// Assumes preamble patterns are given for a line that was low before the subframe.
package spdif_tx_pkg;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_LEFT  = 2'd1,
        PRE_RIGHT = 2'd2
    } pre_e;

    typedef struct packed {
        logic mono;
        logic mute;
        logic in_rel;
        logic out_rel;
        logic enable;
    } ctrl_t;

    // Eight-cell preamble pattern, first cell in the MSB.
    function automatic logic [7:0] pre_pattern(input pre_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_LEFT:  return 8'b1110_0010;
            default:   return 8'b1110_0100;
        endcase
    endfunction

endpackage

// File: rtl/spdif_tx_regs.sv
// Register file: control word at address 0, two channel-status blocks after it.
// Assumes CS_BITS is a multiple of WORD_W and WORD_W >= 5. Write-only.
module spdif_tx_regs
    import spdif_tx_pkg::*;
#(
    parameter int CS_BITS = 192,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output ctrl_t               ctrl,
    output logic [CS_BITS-1:0]  cs_a,
    output logic [CS_BITS-1:0]  cs_b
);
    localparam int CS_WORDS = CS_BITS / WORD_W;
    localparam int A_BASE   = 1;
    localparam int B_BASE   = A_BASE + CS_WORDS;

    logic [WORD_W-1:0] a_q [CS_WORDS];
    logic [WORD_W-1:0] b_q [CS_WORDS];

    // Control word update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_addr == '0)
            ctrl <= ctrl_t'(wr_data[4:0]);
    end

    // Channel-status word updates for both blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < CS_WORDS; w++) begin
                a_q[w] <= '0;
                b_q[w] <= '0;
            end
        end else if (wr_en) begin
            for (int w = 0; w < CS_WORDS; w++) begin
                if (wr_addr == ADDR_W'(A_BASE + w)) a_q[w] <= wr_data;
                if (wr_addr == ADDR_W'(B_BASE + w)) b_q[w] <= wr_data;
            end
        end
    end

    // Flatten the word arrays into bit vectors, word 0 at the bottom.
    for (genvar w = 0; w < CS_WORDS; w++) begin : g_flat
        assign cs_a[w*WORD_W +: WORD_W] = a_q[w];
        assign cs_b[w*WORD_W +: WORD_W] = b_q[w];
    end

endmodule

// File: rtl/spdif_tx_framer.sv
// Frame sequencer: cell and frame counters, sample holding register, slot bit choice.
// Assumes run drops to restart the counters; cell_en is a one-cycle strobe.
module spdif_tx_framer
    import spdif_tx_pkg::*;
#(
    parameter int CS_BITS = 192,
    parameter int WORD_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                in_rel,
    input  logic                cell_en,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [WORD_W-1:0]   smp_left,
    input  logic [WORD_W-1:0]   smp_right,
    input  logic                mono,
    input  logic                mute,
    input  logic [CS_BITS-1:0]  cs_a,
    input  logic [CS_BITS-1:0]  cs_b,
    output logic                is_pre,
    output pre_e                pre_kind,
    output logic [2:0]          pre_cell,
    output logic                second_half,
    output logic                bit_val
);
    localparam int SLOT_W  = $clog2(WORD_W);
    localparam int CELL_W  = SLOT_W + 2;
    localparam int FRAME_W = $clog2(CS_BITS);
    localparam logic [SLOT_W-1:0]  PRE_SLOTS = SLOT_W'(4);
    localparam logic [SLOT_W-1:0]  V_SLOT    = SLOT_W'(WORD_W - 4);
    localparam logic [SLOT_W-1:0]  U_SLOT    = SLOT_W'(WORD_W - 3);
    localparam logic [SLOT_W-1:0]  C_SLOT    = SLOT_W'(WORD_W - 2);
    localparam logic [SLOT_W-1:0]  P_SLOT    = SLOT_W'(WORD_W - 1);
    localparam logic [FRAME_W-1:0] FRAME_END = FRAME_W'(CS_BITS - 1);

    logic [CELL_W-1:0]  cell_q;
    logic [FRAME_W-1:0] frame_q;
    logic [WORD_W-1:0]  hold_l, hold_r, cur_l, cur_r, word;
    logic               hold_full, par_q;
    logic [SLOT_W-1:0]  slot;
    logic               sub, step, frame_start, accept;

    assign slot        = cell_q[SLOT_W:1];
    assign sub         = cell_q[CELL_W-1];
    assign second_half = cell_q[0];
    assign pre_cell    = cell_q[2:0];
    assign is_pre      = slot < PRE_SLOTS;
    assign step        = run && cell_en;
    assign frame_start = step && cell_q == '0;
    assign smp_ready   = in_rel && !hold_full;
    assign accept      = smp_valid && smp_ready;

    // Preamble kind from subframe and frame position.
    always_comb begin
        if (sub)                pre_kind = PRE_RIGHT;
        else if (frame_q == '0) pre_kind = PRE_BLOCK;
        else                    pre_kind = PRE_LEFT;
    end

    // Slot bit selection: audio, validity, user, channel status, parity.
    always_comb begin
        word = (sub && !mono) ? cur_r : cur_l;
        if (slot == V_SLOT)      bit_val = mute;
        else if (slot == U_SLOT) bit_val = 1'b0;
        else if (slot == C_SLOT) bit_val = sub ? cs_b[frame_q] : cs_a[frame_q];
        else if (slot == P_SLOT) bit_val = par_q;
        else                     bit_val = word[slot];
    end

    // Cell and frame counters, cleared whenever transmission is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cell_q  <= '0;
            frame_q <= '0;
        end else if (cell_en) begin
            cell_q <= cell_q + 1'b1;
            if (cell_q == '1)
                frame_q <= (frame_q == FRAME_END) ? '0 : frame_q + 1'b1;
        end
    end

    // One-pair holding register behind the valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l    <= '0;
            hold_r    <= '0;
            hold_full <= 1'b0;
        end else if (!in_rel) begin
            hold_full <= 1'b0;
        end else begin
            if (frame_start) hold_full <= 1'b0;
            if (accept) begin
                hold_l    <= smp_left;
                hold_r    <= smp_right;
                hold_full <= 1'b1;
            end
        end
    end

    // Pair used by the current frame, taken on the frame's first cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_l <= '0;
            cur_r <= '0;
        end else if (frame_start) begin
            cur_l <= hold_full ? hold_l : '0;
            cur_r <= hold_full ? hold_r : '0;
        end
    end

    // Running parity over the data slots of the current subframe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            par_q <= 1'b0;
        else if (step) begin
            if (is_pre)
                par_q <= 1'b0;
            else if (second_half && slot != P_SLOT)
                par_q <= par_q ^ bit_val;
        end
    end

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q < FRAME_W'(CS_BITS)); // R6
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_ready |=> !smp_ready); // R9
    AST_PAIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full && in_rel && !frame_start |=> $stable(hold_l) && $stable(hold_r)); // R9

endmodule

// File: rtl/spdif_tx_bmc.sv
// Line encoder: preamble patterns and biphase-mark coding, one cell per strobe.
// Assumes the framer presents the attributes of the cell about to be sent.
module spdif_tx_bmc
    import spdif_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       cell_en,
    input  logic       is_pre,
    input  pre_e       pre_kind,
    input  logic [2:0] pre_cell,
    input  logic       second_half,
    input  logic       bit_val,
    output logic       line
);
    logic       ref_q, ref_now, line_nxt;
    logic [7:0] pat;

    // Next line level for the current cell.
    always_comb begin
        pat     = pre_pattern(pre_kind);
        ref_now = (pre_cell == 3'd0) ? line : ref_q;
        if (is_pre)           line_nxt = pat[3'd7 - pre_cell] ^ ref_now;
        else if (second_half) line_nxt = line ^ bit_val;
        else                  line_nxt = !line;
    end

    // Line register and the level captured at each subframe start.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line  <= 1'b0;
            ref_q <= 1'b0;
        end else if (cell_en) begin
            line <= line_nxt;
            if (is_pre && pre_cell == 3'd0) ref_q <= line;
        end
    end

    AST_HOLD_BETWEEN_CELLS: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cell_en |=> $stable(line)); // R1
    AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        run && cell_en && !is_pre && !second_half |=> line != $past(line)); // R2
    AST_PARITY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        run && cell_en && is_pre && pre_cell == 3'd0 |-> line == ref_q); // R7

endmodule

// File: rtl/spdif_tx.sv
// Top: serial digital audio frame transmitter.
// Assumes cell_en is a single-cycle strobe at 128 x sample rate.
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int CS_BITS = 192,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_en,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [WORD_W-1:0] smp_left,
    input  logic [WORD_W-1:0] smp_right,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              spdif_out
);
    ctrl_t              ctrl;
    logic [CS_BITS-1:0] cs_a, cs_b;
    logic               run, is_pre, second_half, bit_val;
    pre_e               pre_kind;
    logic [2:0]         pre_cell;

    // Transmission needs enable plus both reset releases.
    assign run = ctrl.enable && ctrl.out_rel && ctrl.in_rel;

    spdif_tx_regs #(.CS_BITS(CS_BITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .ctrl(ctrl), .cs_a(cs_a), .cs_b(cs_b));

    spdif_tx_framer #(.CS_BITS(CS_BITS), .WORD_W(WORD_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .run(run), .in_rel(ctrl.in_rel),
        .cell_en(cell_en), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right), .mono(ctrl.mono),
        .mute(ctrl.mute), .cs_a(cs_a), .cs_b(cs_b), .is_pre(is_pre),
        .pre_kind(pre_kind), .pre_cell(pre_cell), .second_half(second_half),
        .bit_val(bit_val));

    spdif_tx_bmc u_bmc (
        .clk(clk), .rst_n(rst_n), .run(run), .cell_en(cell_en),
        .is_pre(is_pre), .pre_kind(pre_kind), .pre_cell(pre_cell),
        .second_half(second_half), .bit_val(bit_val), .line(spdif_out));

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |=> !spdif_out); // R8

endmodule

// File: tb/spdif_tx_test.sv
module spdif_tx_test;
    localparam int CS_BITS = 192;
    localparam int WORD_W  = 32;
    localparam logic [7:0] PAT_B = 8'b1110_1000;
    localparam logic [7:0] PAT_M = 8'b1110_0010;
    localparam logic [7:0] PAT_W = 8'b1110_0100;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, cell_en = 1'b0, smp_valid = 1'b0, reg_wr = 1'b0;
    logic        smp_ready, spdif_out;
    logic [31:0] smp_left = '0, smp_right = '0, reg_wdata = '0;
    logic [3:0]  reg_addr = '0;

    spdif_tx uut (.clk(clk), .rst_n(rst_n), .cell_en(cell_en), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .spdif_out(spdif_out));

    int errs = 0, checks = 0;
    // Reference state
    logic [CS_BITS-1:0] m_csa = '0, m_csb = '0;
    bit m_en, m_out, m_in, m_mute, m_mono, m_line, m_ref, m_hfull, feed_on;
    int m_cell = 0, m_frame = 0, pair_idx = 0;
    logic [31:0] m_hl = '0, m_hr = '0, m_cl = '0, m_cr = '0;

    function automatic logic [31:0] left_of(input int k);
        return (k * 32'h9E37_79B1) ^ 32'h5000_000A;
    endfunction
    function automatic logic [31:0] right_of(input int k);
        return (k * 32'h85EB_CA6B) ^ 32'hF00D_000F;
    endfunction

    function automatic bit exp_bit(input int slot, input int sub);
        logic [31:0] w;
        bit p;
        w = (sub == 1 && !m_mono) ? m_cr : m_cl;
        if (slot <= 27) return w[slot];
        if (slot == 28) return m_mute;
        if (slot == 29) return 1'b0;
        if (slot == 30) return (sub == 1) ? m_csb[m_frame] : m_csa[m_frame];
        p = 1'b0;
        for (int s = 4; s <= 30; s++) p ^= exp_bit(s, sub);
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at a negedge, update the reference, check at the next negedge.
    task automatic cyc(input bit ce, input bit wr, input logic [3:0] a, input logic [31:0] d);
        bit take, run_now;
        string tag;
        int c, slot, sub;
        logic [7:0] pat;
        cell_en = ce; reg_wr = wr; reg_addr = a; reg_wdata = d;
        smp_valid = feed_on; smp_left = left_of(pair_idx); smp_right = right_of(pair_idx);
        take = feed_on && smp_ready;
        run_now = m_en && m_out && m_in;
        tag = run_now ? "R1 idle cell" : "R8 stopped";
        if (run_now && ce) begin
            c = m_cell % 64; slot = c / 2; sub = m_cell / 64;
            if (m_cell == 0) begin
                m_cl = m_hfull ? m_hl : '0; m_cr = m_hfull ? m_hr : '0; m_hfull = 0;
            end
            if (slot < 4) begin
                if (c == 0) m_ref = m_line;
                pat = (sub == 1) ? PAT_W : (m_frame == 0 ? PAT_B : PAT_M);
                m_line = pat[7 - c] ^ m_ref;
                tag = "R3 preamble";
            end else if (m_cell % 2 == 0) begin
                m_line = !m_line;
                tag = "R2 slot edge";
            end else begin
                m_line = m_line ^ exp_bit(slot, sub);
                if (slot <= 27)      tag = m_mono ? "R4 mono audio" : "R4 audio";
                else if (slot <= 29) tag = "R5 V/U";
                else if (slot == 30) tag = "R6 channel status";
                else                 tag = "R7 parity";
            end
            m_cell++;
            if (m_cell == 128) begin m_cell = 0; m_frame = (m_frame + 1) % CS_BITS; end
        end
        if (take) begin
            m_hl = left_of(pair_idx); m_hr = right_of(pair_idx); m_hfull = 1; pair_idx++;
        end
        if (wr && a == 0) begin
            m_en = d[0]; m_out = d[1]; m_in = d[2]; m_mute = d[3]; m_mono = d[4];
            if (!(m_en && m_out && m_in)) begin
                m_line = 0; m_ref = 0; m_cell = 0; m_frame = 0;
            end
            if (!m_in) m_hfull = 0;
        end
        if (wr && a >= 1 && a <= 6)  m_csa[(a - 1) * 32 +: 32] = d;
        if (wr && a >= 7 && a <= 12) m_csb[(a - 7) * 32 +: 32] = d;
        @(posedge clk);
        @(negedge clk);
        cell_en = 0; reg_wr = 0;
        if (!wr) chk(tag, {31'd0, spdif_out}, {31'd0, m_line});
        chk("R9 ready", {31'd0, smp_ready}, {31'd0, (m_in && !m_hfull)});
    endtask

    task automatic run_cells(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 4'd0, 32'd0);
            if (gaps && i % 5 == 0) cyc(1'b0, 1'b0, 4'd0, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 line after reset", {31'd0, spdif_out}, 32'd0);
        chk("R10 ready after reset", {31'd0, smp_ready}, 32'd0);
        for (int w = 0; w < 6; w++) begin
            cyc(1'b0, 1'b1, 4'(1 + w), 32'hC0DE_1234 ^ (w * 32'h1357_9BDF));
            cyc(1'b0, 1'b1, 4'(7 + w), 32'h0BAD_F00D + (w * 32'h2468_ACE1));
        end
        // Output side released only, then enabled before input release: line stays idle (R8, R9)
        cyc(1'b0, 1'b1, 4'd0, 32'h2);
        run_cells(10, 1'b0);
        cyc(1'b0, 1'b1, 4'd0, 32'h3);
        run_cells(10, 1'b0);
        cyc(1'b0, 1'b1, 4'd0, 32'h6);
        feed_on = 1'b1;
        repeat (3) cyc(1'b0, 1'b0, 4'd0, 32'd0);
        cyc(1'b0, 1'b1, 4'd0, 32'h7);
        // Full 192-frame block plus one, stereo, unmuted (R1..R7)
        run_cells(193 * 128, 1'b0);
        // Mute and mono with gaps between cells (R4, R5)
        cyc(1'b0, 1'b1, 4'd0, 32'h1F);
        run_cells(3 * 128, 1'b1);
        // Mono unmuted, feed cut: held pair then zero frames (R9)
        cyc(1'b0, 1'b1, 4'd0, 32'h17);
        feed_on = 1'b0;
        run_cells(3 * 128, 1'b0);
        feed_on = 1'b1;
        cyc(1'b0, 1'b1, 4'd0, 32'h7);
        run_cells(2 * 128, 1'b0);
        // Mid-frame stop, idle cells, restart from block start (R8)
        run_cells(50, 1'b0);
        cyc(1'b0, 1'b1, 4'd0, 32'h6);
        run_cells(20, 1'b0);
        cyc(1'b0, 1'b1, 4'd0, 32'h7);
        run_cells(2 * 128, 1'b0);
        // Input side back into reset: pair discarded, line idle (R8, R9)
        feed_on = 1'b0;
        cyc(1'b0, 1'b1, 4'd0, 32'h3);
        run_cells(10, 1'b0);
        cyc(1'b0, 1'b1, 4'd0, 32'h7);
        feed_on = 1'b1;
        run_cells(2 * 128, 1'b0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule